// File: doc/BRIEF.md
# Interpolating Sample Scaler

This block sits between a waveform lookup table and an audio output path. Each time the sequencer has fetched two neighbouring table entries (the current entry and the one after it), it raises a one-cycle load strobe. The block then takes those two samples and the fractional part of the phase accumulator. It blends them linearly to estimate the waveform between table points. A two-bit gain select sets one of four amplitude factors, which the block applies to both the blended sample and the plain current sample.

All arithmetic is signed. The table may store offset-binary samples, which are converted on entry. Unsigned operands (the fraction and the gain factor) are zero-extended by one bit so that a signed multiplier treats them correctly. Because scaling happens on signed data, the waveform grows and shrinks symmetrically about zero. Two 18-bit signed results leave the block. The left channel carries the scaled plain sample and the right channel carries the scaled blended sample. Both come with a valid pulse after a fixed pipeline delay.

Top module: `lerp_gain`

## Requirements
- R1: With the default parameter `UNSIGNED_TABLE=1`, each 16-bit table word is read as offset binary and converted to signed by inverting its MSB: code 0x8000 is zero, 0x0000 is -32768 and 0xFFFF is +32767.
- R2: The blended sample equals b + floor((n - b) * f / 1024), where b and n are the converted current and next samples and f is the 10-bit unsigned `frac` input.
- R3: The blended sample always lies between b and n, inclusive; when `frac` is 0 it equals b.
- R4: `gain_sel` codes 0, 1, 2 and 3 select factors 0.5, 1.0, 1.5 and 2.0. A sample s is output as floor(s * factor * 4), so unity gain places the 16-bit sample in the upper bits of the 18-bit output.
- R5: `left_out` carries the scaled b and `right_out` carries the scaled blended sample, both using the same gain captured with the same load.
- R6: A scaled result above 131071 is clamped to 131071, and a result below -131072 is clamped to -131072.
- R7: If `load` is sampled high at rising edge k, the new outputs and a one-cycle `out_valid` pulse appear after rising edge k+2. `out_valid` is low in the two cycles before that.
- R8: After reset both outputs are 0 and `out_valid` is low. Between updates the outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Samples and controls are valid this cycle |
| base_raw | input | 16 | Current table entry |
| next_raw | input | 16 | Following table entry |
| frac | input | 10 | Unsigned fractional phase, in units of 1/1024 |
| gain_sel | input | 2 | Amplitude factor select |
| left_out | output | 18 | Scaled plain sample, signed |
| right_out | output | 18 | Scaled blended sample, signed |
| out_valid | output | 1 | One-cycle pulse when the outputs update |

## Verification
The embedded properties assume that `base_raw`, `next_raw`, `frac` and `gain_sel` are only meaningful in the cycle where `load` is high. They also assume that nothing upstream reuses those values in later cycles. The bench drives every operand together with the load strobe, drops the strobe on the next falling edge, and lets each load drain fully before issuing the next. This keeps pipeline stages from overlapping and satisfies the hold property on the outputs. Operands are chosen to cover both orderings of the two samples, both signs, the conversion end codes and both saturation limits.

// File: rtl/lerp_gain.sv
module lerp_gain #(
  parameter int SW = 16,
  parameter int FW = 10,
  parameter int GW = 8,
  parameter int GFRAC = 6,
  parameter int OW = 18,
  parameter bit UNSIGNED_TABLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] base_raw,
  input  logic [SW-1:0] next_raw,
  input  logic [FW-1:0] frac,
  input  logic [1:0]    gain_sel,
  output logic [OW-1:0] left_out,
  output logic [OW-1:0] right_out,
  output logic          out_valid
);
  localparam int DW = SW + 1;
  localparam int PW = DW + FW + 1;
  localparam int MW = DW + GW + 1;
  localparam int SH = GFRAC - (OW - SW);
  localparam logic [GW-1:0] GUNIT = GW'(1 << GFRAC);
  localparam logic signed [MW-1:0] MAXV = MW'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [MW-1:0] MINV = -MAXV - 1;

  logic [SW-1:0] flip;
  assign flip = UNSIGNED_TABLE ? SW'(1) << (SW - 1) : '0;

  logic [GW-1:0] gain_fac;
  always_comb begin
    case (gain_sel)
      2'd0:    gain_fac = GUNIT >> 1;
      2'd1:    gain_fac = GUNIT;
      2'd2:    gain_fac = GUNIT + (GUNIT >> 1);
      default: gain_fac = GUNIT << 1;
    endcase
  end

  logic signed [SW-1:0] b1, n1;
  logic [FW-1:0] f1;
  logic [GW-1:0] g1, g2;
  logic v1, v2;
  logic signed [DW-1:0] b1x, n1x, diff, step, b2, i2;
  logic signed [PW-1:0] prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1 <= '0; n1 <= '0; f1 <= '0; g1 <= '0; v1 <= 1'b0;
    end else begin
      v1 <= load;
      if (load) begin
        b1 <= base_raw ^ flip;
        n1 <= next_raw ^ flip;
        f1 <= frac;
        g1 <= gain_fac;
      end
    end
  end

  assign b1x  = DW'(b1);
  assign n1x  = DW'(n1);
  assign diff = n1x - b1x;
  assign prod = PW'(diff) * PW'($signed({1'b0, f1}));
  assign step = DW'(prod >>> FW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b2 <= '0; i2 <= '0; g2 <= '0; v2 <= 1'b0;
    end else begin
      v2 <= v1;
      if (v1) begin
        b2 <= b1x;
        i2 <= b1x + step;
        g2 <= g1;
      end
    end
  end

  function automatic logic [OW-1:0] scale(input logic signed [DW-1:0] x,
                                          input logic [GW-1:0] g);
    logic signed [MW-1:0] m;
    m = MW'(x) * MW'($signed({1'b0, g}));
    m = m >>> SH;
    if (m > MAXV) m = MAXV;
    else if (m < MINV) m = MINV;
    return OW'(m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_out <= '0; right_out <= '0; out_valid <= 1'b0;
    end else begin
      out_valid <= v2;
      if (v2) begin
        left_out  <= scale(b2, g2);
        right_out <= scale(i2, g2);
      end
    end
  end

  a_r3_between: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (((i2 >= $past(b1x)) && (i2 <= $past(n1x))) ||
            ((i2 <= $past(b1x)) && (i2 >= $past(n1x)))));

  a_r3_zero_frac: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && $past(f1) == '0) |-> (i2 == b2));

  a_r4_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (left_out[OW-1] == $past(b2[DW-1])));

  a_r6_half_no_clip: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(g2) == (GUNIT >> 1)) |->
      ($signed(right_out) <= $signed(OW'(1 << (OW - 2))) &&
       $signed(right_out) >= -$signed(OW'(1 << (OW - 2)))));

  a_r7_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> v2);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(left_out) && $stable(right_out)));
endmodule

// File: tb/sim_lerp_gain.sv
module sim_lerp_gain;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [15:0] base_raw = '0, next_raw = '0;
  logic [9:0] frac = '0;
  logic [1:0] gain_sel = '0;
  logic [17:0] left_out, right_out;
  logic out_valid;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lerp_gain u0 (.clk(clk), .rst_n(rst_n), .load(load), .base_raw(base_raw),
    .next_raw(next_raw), .frac(frac), .gain_sel(gain_sel),
    .left_out(left_out), .right_out(right_out), .out_valid(out_valid));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint gfac(int sel);
    return (sel + 1) * 32;
  endfunction

  function automatic longint sc(longint s, int sel);
    longint m = (s * gfac(sel)) >>> 4;
    if (m > 131071) m = 131071;
    if (m < -131072) m = -131072;
    return m;
  endfunction

  function automatic longint s18(logic [17:0] v);
    return longint'($signed(v));
  endfunction

  task automatic run(string req, int bs, int ns, int f, int sel);
    longint el, er, il;
    il = bs + (((longint'(ns) - bs) * f) >>> 10);
    el = sc(bs, sel);
    er = sc(il, sel);
    @(negedge clk);
    base_raw = 16'(bs) ^ 16'h8000;
    next_raw = 16'(ns) ^ 16'h8000;
    frac = 10'(f);
    gain_sel = 2'(sel);
    load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    base_raw = 16'h1234; next_raw = 16'h4321; frac = 10'd777; gain_sel = 2'd3;
    chk({req, " R7 valid low +1"}, out_valid, 0);
    @(negedge clk);
    chk({req, " R7 valid low +2"}, out_valid, 0);
    @(negedge clk);
    chk({req, " R7 valid pulse"}, out_valid, 1);
    chk({req, " R5 left"}, s18(left_out), el);
    chk({req, " R5 right"}, s18(right_out), er);
    @(negedge clk);
    chk({req, " R7 single pulse"}, out_valid, 0);
    chk({req, " R8 left hold"}, s18(left_out), el);
    chk({req, " R8 right hold"}, s18(right_out), er);
  endtask

  task automatic t_reset();
    chk("R8 reset left", s18(left_out), 0);
    chk("R8 reset right", s18(right_out), 0);
    chk("R8 reset valid", out_valid, 0);
  endtask

  task automatic t_convert();
    @(negedge clk);
    base_raw = 16'h8000; next_raw = 16'h8000; frac = 0; gain_sel = 1; load = 1;
    @(negedge clk); load = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 code 0x8000 is zero", s18(left_out), 0);
    @(negedge clk);
    base_raw = 16'h0000; next_raw = 16'hFFFF; frac = 0; gain_sel = 1; load = 1;
    @(negedge clk); load = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 code 0x0000 is -32768", s18(left_out), -131072);
    @(negedge clk);
    base_raw = 16'hFFFF; next_raw = 16'h0000; frac = 0; gain_sel = 1; load = 1;
    @(negedge clk); load = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 code 0xFFFF is +32767", s18(left_out), 131068);
  endtask

  task automatic t_interp();
    run("R2 pos n>b", 1000, 3000, 256, 1);
    run("R2 pos b>n", 5000, 1000, 700, 1);
    run("R2 neg n>b", -3000, -100, 513, 1);
    run("R2 neg b>n", -100, -300, 1, 1);
    run("R3 frac zero", 1234, -5000, 0, 1);
    run("R3 frac max", -20000, 20000, 1023, 1);
  endtask

  task automatic t_gain();
    run("R4 gain 0.5", 10000, -10000, 300, 0);
    run("R4 gain 1.0", -7777, 3333, 900, 1);
    run("R4 gain 1.5", 12001, 9000, 100, 2);
    run("R4 gain 2.0", -9001, -12000, 600, 3);
  endtask

  task automatic t_sat();
    run("R6 clip high", 30000, 32767, 512, 3);
    run("R6 clip low", -30000, -32768, 512, 3);
    run("R6 gain 1.5 edge", 32767, -32768, 512, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_convert();
    t_interp();
    t_gain();
    t_sat();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule